// File: doc/BRIEF.md
# Posted Write Flush Timer

This block decides when write data that has been posted into an inbound buffer must be pushed out to memory. Each time an inbound write finishes on the bus, the block samples a 3-bit timeout code. It then loads a down-counter with the power-of-two delay that the code selects. The counter drops by one on every bus clock. When it expires, the block raises a flush request, provided the buffer still holds data.

One code value switches timed flushing off completely. A later write that completes before expiry restarts the count from the full delay. The flush request is a level. It stays up until the memory side acknowledges the flush. The timer then waits, idle, for the next completed write. The buffer storage and the memory write path lie outside the block.

Top module: `pwflush_timer`

## Requirements
- R1: While reset is asserted, and on the first clock after its release, `flush_req` is low and no countdown is running.
- R2: A write completion sampled with code c (binary, c from 0 to 6) sets a delay of N = 2^(c+2) clocks, that is 4, 8, 16, 32, 64, 128 or 256. If no further write completes and the buffer is non-empty on the expiry edge, `flush_req` rises at the N-th rising edge after the edge that sampled `wr_done`, and not before.
- R3: A write completion sampled with code 7 (all ones) starts no countdown. It also cancels any countdown already running, so no timed flush follows.
- R4: A write completion that arrives during a countdown restarts the countdown at the full delay of the code sampled with that write.
- R5: The code is read only on the clock where a write completes. Changing it during a countdown has no effect on that countdown.
- R6: Once raised, `flush_req` stays high until `flush_ack` is sampled high. It is low from the following edge on.
- R7: If `buf_nonempty` is low on the expiry edge, no request is raised and the timer goes idle.
- R8: Write completions sampled while `flush_req` is high are ignored. No countdown is running once the acknowledge has been taken.
- R9: After an expiry, with or without a request, no further request appears until another write completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmo_code | input | 3 | Timeout code sampled with each write completion; 7 disables timing |
| wr_done | input | 1 | One-cycle strobe: an inbound write has finished on the bus |
| buf_nonempty | input | 1 | The posted write buffer holds data |
| flush_ack | input | 1 | The memory side has completed the requested flush |
| flush_req | output | 1 | Request to push posted data to memory |

## Verification
The bench builds the block with its default parameters: a 3-bit code and a shortest delay of 4 clocks. This gives a 9-bit counter whose longest delay is 256 clocks. Every code, including the longest delay and the disable code, can therefore be walked through exactly, edge by edge, within the run. The directed part covers the exact rise edge for each delay, restarts and code changes during a count, cancellation, and an empty buffer at expiry. The random part mixes overlapping writes, acknowledges held back for several cycles, and buffer-empty expiries.

// File: rtl/pwf_pkg.sv
package pwf_pkg;

    typedef enum logic [1:0] {
        PWF_IDLE  = 2'd0,
        PWF_COUNT = 2'd1,
        PWF_FLUSH = 2'd2
    } pwf_state_e;

    typedef struct packed {
        pwf_state_e st;
        logic       req;
    } pwf_ctrl_t;

endpackage

// File: rtl/pwf_delay_decode.sv
module pwf_delay_decode #(
    parameter int CODE_W    = 3,
    parameter int MIN_SHIFT = 2,
    parameter int CNT_W     = MIN_SHIFT + (2**CODE_W) - 1
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  load_val,
    output logic              timed
);
    localparam int NUM_DLY = (2**CODE_W) - 1;

    always_comb begin
        load_val = '0;
        for (int i = 0; i < NUM_DLY; i++) begin
            if (code == CODE_W'(i)) begin
                load_val = CNT_W'(1) << (MIN_SHIFT + i);
            end
        end
        timed = (code != '1);
    end
endmodule

// File: rtl/pwf_down_counter.sv
module pwf_down_counter #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         last
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (run && cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == W'(1));
endmodule

// File: rtl/pwflush_timer.sv
module pwflush_timer
    import pwf_pkg::*;
#(
    parameter int CODE_W    = 3,
    parameter int MIN_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] tmo_code,
    input  logic              wr_done,
    input  logic              buf_nonempty,
    input  logic              flush_ack,
    output logic              flush_req
);
    localparam int CNT_W = MIN_SHIFT + (2**CODE_W) - 1;

    pwf_ctrl_t        ctrl_d, ctrl_q;
    logic [CNT_W-1:0] load_val;
    logic             timed;
    logic             cnt_load, cnt_run, cnt_last;

    pwf_delay_decode #(
        .CODE_W   (CODE_W),
        .MIN_SHIFT(MIN_SHIFT),
        .CNT_W    (CNT_W)
    ) u_decode (
        .code    (tmo_code),
        .load_val(load_val),
        .timed   (timed)
    );

    pwf_down_counter #(
        .W(CNT_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(load_val),
        .run     (cnt_run),
        .last    (cnt_last)
    );

    always_comb begin
        ctrl_d   = ctrl_q;
        cnt_load = 1'b0;
        cnt_run  = 1'b0;
        if (ctrl_q.st == PWF_FLUSH) begin
            // writes during a pending flush ride along with it
            if (flush_ack) begin
                ctrl_d.st = PWF_IDLE;
            end
        end else if (wr_done) begin
            if (timed) begin
                cnt_load  = 1'b1;
                ctrl_d.st = PWF_COUNT;
            end else begin
                ctrl_d.st = PWF_IDLE;
            end
        end else if (ctrl_q.st == PWF_COUNT) begin
            if (cnt_last) begin
                ctrl_d.st = buf_nonempty ? PWF_FLUSH : PWF_IDLE;
            end else begin
                cnt_run = 1'b1;
            end
        end
        ctrl_d.req = (ctrl_d.st == PWF_FLUSH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{st: PWF_IDLE, req: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign flush_req = ctrl_q.req;
endmodule

// File: rtl/pwf_checker.sv
module pwf_checker #(
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] tmo_code,
    input logic              wr_done,
    input logic              buf_nonempty,
    input logic              flush_ack,
    input logic              flush_req
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !flush_req);

    assert_min_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_req && wr_done) |=> !flush_req);

    assert_disabled_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_req && wr_done && tmo_code == '1) |=> !flush_req);

    assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_ack) |=> flush_req);

    assert_drop_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && flush_ack) |=> !flush_req);

    assert_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_req) |-> $past(buf_nonempty));
endmodule

bind pwflush_timer pwf_checker #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmo_code    (tmo_code),
    .wr_done     (wr_done),
    .buf_nonempty(buf_nonempty),
    .flush_ack   (flush_ack),
    .flush_req   (flush_req)
);

// File: tb/pwflush_timer_tb.sv
module pwflush_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] tmo_code = '0;
    logic       wr_done = 1'b0;
    logic       buf_nonempty = 1'b0;
    logic       flush_ack = 1'b0;
    logic       flush_req;

    int vectors = 0;
    int errors = 0;
    int m_st = 0;   // 0 idle, 1 counting, 2 flush pending
    int m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwflush_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tmo_code(tmo_code), .wr_done(wr_done),
        .buf_nonempty(buf_nonempty), .flush_ack(flush_ack), .flush_req(flush_req)
    );

    function automatic int delay_of(logic [2:0] c);
        return (c == 3'd7) ? 0 : (4 << c);
    endfunction

    task automatic check(string tag, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: flush_req=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // apply inputs, clock once, update the model, compare after the edge
    task automatic cyc(logic wr, logic [2:0] c, logic ne, logic ack, string tag);
        wr_done = wr; tmo_code = c; buf_nonempty = ne; flush_ack = ack;
        @(posedge clk);
        if (m_st == 2) begin
            if (ack) m_st = 0;
        end else if (wr) begin
            if (delay_of(c) == 0) m_st = 0;
            else begin m_st = 1; m_cnt = delay_of(c); end
        end else if (m_st == 1) begin
            if (m_cnt == 1) m_st = ne ? 2 : 0;
            else m_cnt--;
        end
        #1;
        check(tag, flush_req, m_st == 2);
    endtask

    task automatic idle(int n, logic ne, string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, ne, 1'b0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        #1;
        check("R1", flush_req, 1'b0);
        repeat (3) @(posedge clk);
        #1;
        check("R1", flush_req, 1'b0);
        rst_n = 1'b1;
        cyc(1'b0, 3'd0, 1'b1, 1'b0, "R1");

        // exact delay for each timed code
        for (int c = 0; c < 7; c++) begin
            cyc(1'b1, 3'(c), 1'b1, 1'b0, "R2");
            idle(delay_of(3'(c)), 1'b1, "R2");
            check("R2", flush_req, 1'b1);
            cyc(1'b0, 3'd0, 1'b1, 1'b0, "R6");
            cyc(1'b0, 3'd0, 1'b1, 1'b1, "R6");
            idle(300, 1'b1, "R9");
        end

        // disable code, alone and cancelling a running count
        cyc(1'b1, 3'd7, 1'b1, 1'b0, "R3");
        idle(300, 1'b1, "R3");
        cyc(1'b1, 3'd2, 1'b1, 1'b0, "R3");
        idle(5, 1'b1, "R3");
        cyc(1'b1, 3'd7, 1'b1, 1'b0, "R3");
        idle(40, 1'b1, "R3");

        // restart with a different code mid-count
        cyc(1'b1, 3'd3, 1'b1, 1'b0, "R4");
        idle(20, 1'b1, "R4");
        cyc(1'b1, 3'd1, 1'b1, 1'b0, "R4");
        idle(8, 1'b1, "R4");
        check("R4", flush_req, 1'b1);
        cyc(1'b0, 3'd0, 1'b1, 1'b1, "R6");

        // code changes between writes are ignored
        cyc(1'b1, 3'd0, 1'b1, 1'b0, "R5");
        for (int i = 0; i < 4; i++) cyc(1'b0, 3'd6, 1'b1, 1'b0, "R5");
        check("R5", flush_req, 1'b1);
        cyc(1'b0, 3'd0, 1'b1, 1'b1, "R6");

        // empty buffer on the expiry edge
        cyc(1'b1, 3'd1, 1'b1, 1'b0, "R7");
        idle(7, 1'b1, "R7");
        cyc(1'b0, 3'd0, 1'b0, 1'b0, "R7");
        check("R7", flush_req, 1'b0);
        idle(300, 1'b1, "R9");

        // writes while a request is pending
        cyc(1'b1, 3'd0, 1'b1, 1'b0, "R8");
        idle(4, 1'b1, "R8");
        cyc(1'b1, 3'd0, 1'b1, 1'b0, "R8");
        cyc(1'b1, 3'd2, 1'b1, 1'b1, "R8");
        idle(40, 1'b1, "R8");

        // random mix
        for (int i = 0; i < 6000; i++) begin
            logic wr, ne, ack;
            logic [2:0] c;
            wr  = ($urandom_range(0, 24) == 0);
            c   = 3'($urandom_range(0, 7));
            ne  = ($urandom_range(0, 6) != 0);
            ack = (m_st == 2) && ($urandom_range(0, 2) == 0);
            cyc(wr, c, ne, ack, "R2");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule